// File: doc/BRIEF.md
# Duty-Cycled Radio Wake Controller

This block manages the receive schedule of a battery-powered radio node. The node mostly sleeps with its receiver off. At a fixed interval it opens a short listen window. A complete wake packet that arrives inside that window moves the node into an active mode, where the receiver stays on. Active mode lasts until a long stretch passes with no valid traffic. Every valid packet restarts that stretch. A go-to-sleep command, or the node's host link being plugged in, ends active mode at once.

While active, the node answers a broadcast discovery request. It picks one of 32 reply slots at random, waits that many slot periods, and then asks the transmitter for three acknowledge packets in a row. A discovery request addressed to this node alone mutes its answers to broadcast discovery for a timed window. All intervals are counted in ticks of an external timebase, so the same logic serves both the real millisecond schedule and short simulation runs. Packet decoding happens upstream. The block sees only a valid strobe, the packet type and two address-match flags.

Top module: `radio_wake_ctrl`

## Requirements
- R1: After reset the mode output is sleep (code 0), the receiver enable is low and no transmit request is raised.
- R2: Mode codes are 0 sleep, 1 listen, 2 active. Sleep lasts SLEEP_TICKS ticks and is followed by a listen window of LISTEN_TICKS ticks with the receiver enabled. If no wake packet arrives, sleep follows again. The receiver enable is high exactly in listen and active.
- R3: A valid packet of type 0x00 during listen, with host-connected low, puts the block in active mode on the next cycle.
- R4: Active mode returns to sleep after ACTIVE_TICKS ticks without a valid packet. Any valid packet in active mode restarts this count.
- R5: While host-connected is high, active mode falls to sleep on the next cycle and wake packets in listen are ignored (listen continues).
- R6: A valid type 0x18 packet in active mode with the self-match or broadcast flag set gives sleep on the next cycle. With neither flag set it is ignored.
- R7: A valid type 0x11 packet with the broadcast flag in active mode, while the block is not muted and no reply is pending, takes the slot index from the low 5 bits of the random register. The index appears on the slot output. The transmit request rises once slot×SLOT_TICKS ticks have passed.
- R8: The transmit request stays high until ACK_COUNT (3) transmit-done strobes have arrived, then drops.
- R9: A valid type 0x11 packet with the self-match flag in active mode mutes broadcast discovery for MUTE_TICKS ticks. After that window, broadcast discovery is answered again.
- R10: The random register is 16 bits wide and reset to 0xACE1. On each tick it shifts left and takes bit15^bit13^bit12^bit10 into bit 0.
- R11: A broadcast discovery that arrives while a reply is pending is ignored. Leaving active mode cancels a pending or running reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe |
| pkt_valid_i | input | 1 | Strobe: a checked packet was received |
| pkt_type_i | input | 8 | Type byte of that packet |
| addr_self_i | input | 1 | Packet address equals this node |
| addr_bcast_i | input | 1 | Packet address is the all-ones broadcast |
| host_conn_i | input | 1 | Host link connected level |
| tx_done_i | input | 1 | Transmitter finished one acknowledge packet |
| rx_en_o | output | 1 | Receiver enable |
| mode_o | output | 2 | Current mode code |
| tx_req_o | output | 1 | Request to send acknowledge packets |
| slot_o | output | 5 | Chosen reply slot |

## Verification
A wrong mode or a wrong timer count shows at the mode and receiver-enable outputs within one tick of the interval boundary. A reference model compares them on every clock, so a counter that is off by one fails within a few cycles of the expected change. A corrupt random register shows up as a wrong slot index on the first discovery. A wrong mute or slot count shows as a transmit request raised too early, too late or not at all.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_LISTEN = 2'd1,
    MODE_ACTIVE = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    RP_IDLE = 2'd0,
    RP_WAIT = 2'd1,
    RP_SEND = 2'd2
  } reply_e;

  localparam logic [7:0] PT_WAKE  = 8'h00;
  localparam logic [7:0] PT_DISC  = 8'h11;
  localparam logic [7:0] PT_SLEEP = 8'h18;

  localparam int          RND_W    = 16;
  localparam logic [15:0] RND_SEED = 16'hACE1;
endpackage

// File: rtl/wake_lfsr.sv
module wake_lfsr
  import wake_pkg::*;
#(
  parameter int OUT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [OUT_W-1:0] rnd_o
);
  logic [RND_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (tick_i) st_d = {st_q[RND_W-2:0], st_q[15] ^ st_q[13] ^ st_q[12] ^ st_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RND_SEED;
    else        st_q <= st_d;
  end

  assign rnd_o = st_q[OUT_W-1:0];
endmodule

// File: rtl/wake_mode_fsm.sv
module wake_mode_fsm
  import wake_pkg::*;
#(
  parameter int SLEEP_TICKS  = 326,
  parameter int LISTEN_TICKS = 4,
  parameter int ACTIVE_TICKS = 60000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  input  logic  pkt_any_i,
  input  logic  wake_i,
  input  logic  sleep_cmd_i,
  input  logic  host_i,
  output mode_e mode_o
);
  localparam int MAX_A = (SLEEP_TICKS > LISTEN_TICKS) ? SLEEP_TICKS : LISTEN_TICKS;
  localparam int MAX_T = (ACTIVE_TICKS > MAX_A) ? ACTIVE_TICKS : MAX_A;
  localparam int TMR_W = $clog2(MAX_T + 1);

  mode_e            mode_q, mode_d;
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      MODE_SLEEP: begin
        if (tick_i) begin
          if (cnt_q == TMR_W'(SLEEP_TICKS - 1)) begin
            mode_d = MODE_LISTEN;
            cnt_d  = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      MODE_LISTEN: begin
        if (wake_i && !host_i) begin
          mode_d = MODE_ACTIVE;
          cnt_d  = '0;
        end else if (tick_i) begin
          if (cnt_q == TMR_W'(LISTEN_TICKS - 1)) begin
            mode_d = MODE_SLEEP;
            cnt_d  = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      MODE_ACTIVE: begin
        if (host_i || sleep_cmd_i) begin
          mode_d = MODE_SLEEP;
          cnt_d  = '0;
        end else if (pkt_any_i) begin
          cnt_d = '0;
        end else if (tick_i) begin
          if (cnt_q == TMR_W'(ACTIVE_TICKS - 1)) begin
            mode_d = MODE_SLEEP;
            cnt_d  = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        mode_d = MODE_SLEEP;
        cnt_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/wake_reply.sv
module wake_reply
  import wake_pkg::*;
#(
  parameter int MUTE_TICKS = 2000,
  parameter int SLOT_TICKS = 8,
  parameter int SLOT_BITS  = 5,
  parameter int ACK_COUNT  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 active_i,
  input  logic                 disc_bcast_i,
  input  logic                 disc_self_i,
  input  logic                 tx_done_i,
  input  logic [SLOT_BITS-1:0] rnd_i,
  output logic                 tx_req_o,
  output logic [SLOT_BITS-1:0] slot_o
);
  localparam int REM_W  = SLOT_BITS + $clog2(SLOT_TICKS + 1);
  localparam int MUTE_W = $clog2(MUTE_TICKS + 1);
  localparam int ACK_W  = $clog2(ACK_COUNT + 1);

  reply_e               st_q, st_d;
  logic [REM_W-1:0]     rem_q, rem_d;
  logic [MUTE_W-1:0]    mute_q, mute_d;
  logic [ACK_W-1:0]     sent_q, sent_d;
  logic [SLOT_BITS-1:0] slot_q, slot_d;

  always_comb begin
    mute_d = mute_q;
    if (disc_self_i)                  mute_d = MUTE_W'(MUTE_TICKS);
    else if (tick_i && mute_q != '0)  mute_d = mute_q - 1'b1;
  end

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    sent_d = sent_q;
    slot_d = slot_q;
    if (!active_i) begin
      st_d   = RP_IDLE;
      sent_d = '0;
    end else begin
      unique case (st_q)
        RP_IDLE: begin
          if (disc_bcast_i && mute_q == '0) begin
            st_d   = RP_WAIT;
            slot_d = rnd_i;
            rem_d  = REM_W'(rnd_i) * REM_W'(SLOT_TICKS);
          end
        end
        RP_WAIT: begin
          if (rem_q == '0) begin
            st_d   = RP_SEND;
            sent_d = '0;
          end else if (tick_i) rem_d = rem_q - 1'b1;
        end
        RP_SEND: begin
          if (tx_done_i) begin
            if (sent_q == ACK_W'(ACK_COUNT - 1)) st_d = RP_IDLE;
            else sent_d = sent_q + 1'b1;
          end
        end
        default: st_d = RP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RP_IDLE;
      rem_q  <= '0;
      mute_q <= '0;
      sent_q <= '0;
      slot_q <= '0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      mute_q <= mute_d;
      sent_q <= sent_d;
      slot_q <= slot_d;
    end
  end

  assign tx_req_o = (st_q == RP_SEND) && active_i;
  assign slot_o   = slot_q;
endmodule

// File: rtl/radio_wake_ctrl.sv
module radio_wake_ctrl
  import wake_pkg::*;
#(
  parameter int SLEEP_TICKS  = 326,
  parameter int LISTEN_TICKS = 4,
  parameter int ACTIVE_TICKS = 60000,
  parameter int MUTE_TICKS   = 2000,
  parameter int SLOT_TICKS   = 8,
  parameter int SLOT_BITS    = 5,
  parameter int ACK_COUNT    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 pkt_valid_i,
  input  logic [7:0]           pkt_type_i,
  input  logic                 addr_self_i,
  input  logic                 addr_bcast_i,
  input  logic                 host_conn_i,
  input  logic                 tx_done_i,
  output logic                 rx_en_o,
  output logic [1:0]           mode_o,
  output logic                 tx_req_o,
  output logic [SLOT_BITS-1:0] slot_o
);
  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  mode_e                mode;
  logic                 active;
  logic                 wake_pkt, sleep_cmd, disc_bcast, disc_self;
  logic [SLOT_BITS-1:0] rnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign active     = (mode == MODE_ACTIVE);
  assign wake_pkt   = pkt_valid_i && (pkt_type_i == PT_WAKE);
  assign sleep_cmd  = pkt_valid_i && (pkt_type_i == PT_SLEEP) && (addr_self_i || addr_bcast_i);
  assign disc_self  = active && pkt_valid_i && (pkt_type_i == PT_DISC) && addr_self_i;
  assign disc_bcast = active && pkt_valid_i && (pkt_type_i == PT_DISC) && addr_bcast_i && !addr_self_i;

  wake_lfsr #(.OUT_W(SLOT_BITS)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick_i(tick_i),
    .rnd_o (rnd)
  );

  wake_mode_fsm #(
    .SLEEP_TICKS (SLEEP_TICKS),
    .LISTEN_TICKS(LISTEN_TICKS),
    .ACTIVE_TICKS(ACTIVE_TICKS)
  ) u_mode (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (tick_i),
    .pkt_any_i  (pkt_valid_i),
    .wake_i     (wake_pkt),
    .sleep_cmd_i(sleep_cmd),
    .host_i     (host_conn_i),
    .mode_o     (mode)
  );

  wake_reply #(
    .MUTE_TICKS(MUTE_TICKS),
    .SLOT_TICKS(SLOT_TICKS),
    .SLOT_BITS (SLOT_BITS),
    .ACK_COUNT (ACK_COUNT)
  ) u_reply (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .tick_i      (tick_i),
    .active_i    (active),
    .disc_bcast_i(disc_bcast),
    .disc_self_i (disc_self),
    .tx_done_i   (tx_done_i),
    .rnd_i       (rnd),
    .tx_req_o    (tx_req_o),
    .slot_o      (slot_o)
  );

  assign mode_o  = mode;
  assign rx_en_o = (mode != MODE_SLEEP);
endmodule

// File: rtl/radio_wake_ctrl_chk.sv
module radio_wake_ctrl_chk #(
  parameter int SLOT_BITS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pkt_valid_i,
  input logic [7:0]           pkt_type_i,
  input logic                 addr_self_i,
  input logic                 addr_bcast_i,
  input logic                 host_conn_i,
  input logic                 rx_en_o,
  input logic [1:0]           mode_o,
  input logic                 tx_req_o,
  input logic [SLOT_BITS-1:0] slot_o
);
  p_sleep_rx_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> !rx_en_o);

  p_listen_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && $past(mode_o) != 2'd1) |-> ($past(mode_o) == 2'd0));

  p_active_rx_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> rx_en_o);

  p_wake_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && pkt_valid_i && pkt_type_i == 8'h00 && !host_conn_i) |=> (mode_o == 2'd2));

  p_host_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && host_conn_i) |=> (mode_o == 2'd0));

  p_sleep_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && pkt_valid_i && pkt_type_i == 8'h18 && (addr_self_i || addr_bcast_i))
      |=> (mode_o == 2'd0));

  p_req_only_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> (mode_o == 2'd2));

  p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_o && $past(tx_req_o)) |-> $stable(slot_o));
endmodule

bind radio_wake_ctrl radio_wake_ctrl_chk #(.SLOT_BITS(SLOT_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_valid_i (pkt_valid_i),
  .pkt_type_i  (pkt_type_i),
  .addr_self_i (addr_self_i),
  .addr_bcast_i(addr_bcast_i),
  .host_conn_i (host_conn_i),
  .rx_en_o     (rx_en_o),
  .mode_o      (mode_o),
  .tx_req_o    (tx_req_o),
  .slot_o      (slot_o)
);

// File: tb/radio_wake_ctrl_bench.sv
`timescale 1ns/1ps
module radio_wake_ctrl_bench;
  localparam int SLP = 10, LST = 4, ACT = 100, MUT = 20, SLT = 2, ACKN = 3;

  logic clk, rst_n, tick_i, pkt_valid_i, addr_self_i, addr_bcast_i, host_conn_i, tx_done_i;
  logic [7:0] pkt_type_i;
  logic rx_en_o, tx_req_o;
  logic [1:0] mode_o;
  logic [4:0] slot_o;

  int checks = 0, errors = 0, cyc = 0, wd = 0;
  bit tick_en = 0, req_seen = 0;
  int done_cnt = 0;

  radio_wake_ctrl #(.SLEEP_TICKS(SLP), .LISTEN_TICKS(LST), .ACTIVE_TICKS(ACT),
    .MUTE_TICKS(MUT), .SLOT_TICKS(SLT), .SLOT_BITS(5), .ACK_COUNT(ACKN)) u_radio_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pkt_valid_i(pkt_valid_i),
    .pkt_type_i(pkt_type_i), .addr_self_i(addr_self_i), .addr_bcast_i(addr_bcast_i),
    .host_conn_i(host_conn_i), .tx_done_i(tx_done_i), .rx_en_o(rx_en_o),
    .mode_o(mode_o), .tx_req_o(tx_req_o), .slot_o(slot_o));

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_mode, m_cnt, m_lfsr, m_st, m_rem, m_sent, m_mute, m_slot, rel;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_lfsr = 16'hACE1; m_st = 0; m_rem = 0;
      m_sent = 0; m_mute = 0; m_slot = 0; rel = 0;
    end else begin
      rel++;
      if (rel >= 3) begin
        bit act, dsb, dss; int n_mode, n_cnt, n_lfsr, n_mute;
        act = (m_mode == 2);
        dss = act && pkt_valid_i && pkt_type_i == 8'h11 && addr_self_i;
        dsb = act && pkt_valid_i && pkt_type_i == 8'h11 && addr_bcast_i && !addr_self_i;
        n_lfsr = m_lfsr;
        if (tick_i)
          n_lfsr = ((m_lfsr << 1) & 16'hFFFF) |
                   (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1);
        n_mode = m_mode; n_cnt = m_cnt;
        if (m_mode == 0) begin
          if (tick_i) begin
            if (m_cnt == SLP - 1) begin n_mode = 1; n_cnt = 0; end else n_cnt = m_cnt + 1;
          end
        end else if (m_mode == 1) begin
          if (pkt_valid_i && pkt_type_i == 8'h00 && !host_conn_i) begin n_mode = 2; n_cnt = 0; end
          else if (tick_i) begin
            if (m_cnt == LST - 1) begin n_mode = 0; n_cnt = 0; end else n_cnt = m_cnt + 1;
          end
        end else begin
          if (host_conn_i || (pkt_valid_i && pkt_type_i == 8'h18 && (addr_self_i || addr_bcast_i))) begin
            n_mode = 0; n_cnt = 0;
          end else if (pkt_valid_i) n_cnt = 0;
          else if (tick_i) begin
            if (m_cnt == ACT - 1) begin n_mode = 0; n_cnt = 0; end else n_cnt = m_cnt + 1;
          end
        end
        n_mute = m_mute;
        if (dss) n_mute = MUT;
        else if (tick_i && m_mute > 0) n_mute = m_mute - 1;
        if (!act) begin m_st = 0; m_sent = 0; end
        else if (m_st == 0) begin
          if (dsb && m_mute == 0) begin m_st = 1; m_slot = m_lfsr & 31; m_rem = (m_lfsr & 31) * SLT; end
        end else if (m_st == 1) begin
          if (m_rem == 0) begin m_st = 2; m_sent = 0; end
          else if (tick_i) m_rem = m_rem - 1;
        end else begin
          if (tx_done_i) begin
            if (m_sent == ACKN - 1) m_st = 0; else m_sent = m_sent + 1;
          end
        end
        m_mode = n_mode; m_cnt = n_cnt; m_lfsr = n_lfsr; m_mute = n_mute;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && rel >= 1) begin
      chk("R2 rx_en", int'(rx_en_o), (m_mode != 0) ? 1 : 0);
      chk("R4 mode", int'(mode_o), m_mode);
      chk("R8 tx_req", int'(tx_req_o), (m_st == 2 && m_mode == 2) ? 1 : 0);
      chk("R7 R10 slot", int'(slot_o), m_slot);
    end
    if (tx_req_o) req_seen = 1;
    if (tx_req_o && tx_done_i) done_cnt++;
  end

  // timebase and transmitter stand-in
  always @(posedge clk) begin
    #2;
    cyc++;
    tick_i    = tick_en && (cyc % 4 == 0);
    tx_done_i = tx_req_o && (cyc % 3 == 1);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [7:0] t, input bit s, input bit b);
    @(posedge clk); #2;
    pkt_valid_i = 1; pkt_type_i = t; addr_self_i = s; addr_bcast_i = b;
    @(posedge clk); #2;
    pkt_valid_i = 0; pkt_type_i = 8'h00; addr_self_i = 0; addr_bcast_i = 0;
  endtask

  task automatic wait_mode(input int m);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (int'(mode_o) == m) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wake_up();
    wait_mode(1);
    send(8'h00, 0, 0);
    idle(1);
  endtask

  initial begin
    rst_n = 0; pkt_valid_i = 0; pkt_type_i = 0; addr_self_i = 0; addr_bcast_i = 0;
    host_conn_i = 0; tick_i = 0; tx_done_i = 0;
    idle(4);
    @(posedge clk); #2 rst_n = 1;
    idle(4);
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 rx_en", int'(rx_en_o), 0);
    chk("R1 tx_req", int'(tx_req_o), 0);
    tick_en = 1;

    wait_mode(1);
    chk("R2 listen rx on", int'(rx_en_o), 1);
    wait_mode(0);
    chk("R2 back to sleep", int'(rx_en_o), 0);

    // host blocks wake
    host_conn_i = 1;
    wait_mode(1);
    send(8'h00, 0, 0);
    idle(2);
    chk("R5 wake ignored", int'(mode_o), 1);
    wait_mode(0);
    host_conn_i = 0;

    wake_up();
    chk("R3 active", int'(mode_o), 2);

    // retrigger: 15 x 30 cycles exceeds the active length
    for (int k = 0; k < 15; k++) begin
      idle(30);
      send(8'h14, 1, 0);
    end
    chk("R4 retriggered", int'(mode_o), 2);
    idle(420);
    chk("R4 timeout", (int'(mode_o) == 2) ? 1 : 0, 0);

    // discovery reply
    wake_up();
    req_seen = 0; done_cnt = 0;
    send(8'h11, 0, 1);
    for (int i = 0; i < 400 && !req_seen; i++) @(negedge clk);
    chk("R7 reply raised", int'(req_seen), 1);
    for (int i = 0; i < 100 && tx_req_o; i++) @(negedge clk);
    chk("R8 ack count", done_cnt, ACKN);

    // mute
    send(8'h11, 1, 0);
    req_seen = 0;
    send(8'h11, 0, 1);
    idle(60);
    chk("R9 muted", int'(req_seen), 0);
    idle(40);
    send(8'h11, 0, 1);
    for (int i = 0; i < 400 && !req_seen; i++) @(negedge clk);
    chk("R9 unmuted reply", int'(req_seen), 1);
    for (int i = 0; i < 100 && tx_req_o; i++) @(negedge clk);

    // go-to-sleep
    send(8'h18, 0, 0);
    idle(1);
    chk("R6 unaddressed ignored", int'(mode_o), 2);
    send(8'h18, 1, 0);
    idle(1);
    chk("R6 sleep cmd", int'(mode_o), 0);

    // pending reply: second discovery ignored, then abort on host
    wake_up();
    send(8'h11, 0, 1);
    idle(8);
    send(8'h11, 0, 1);
    idle(1);
    chk("R11 slot kept", int'(slot_o), m_slot);
    host_conn_i = 1;
    idle(2);
    req_seen = 0;
    chk("R11 abort mode", int'(mode_o), 0);
    idle(300);
    chk("R11 no reply after abort", int'(req_seen), 0);
    host_conn_i = 0;
    idle(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule